// File: doc/BRIEF.md
# PCI Function Configuration Header

This block holds the standard 64-byte configuration header of a single PCI device function and serves it through a plain configuration access port. Software addresses the space by byte offset. Each access covers one aligned dword, and four byte enables pick the lanes a write touches, so byte, word and dword accesses all follow the same rules. Multibyte fields are little-endian: the lowest offset carries the least significant byte.

The identification fields are read-only. They are the vendor, device, revision, programming interface, class and subsystem identifiers, and they are set by parameters at build time. The interrupt pin number is also read-only. Writable state is limited to the three decode enables in the command register and the interrupt line byte. Everything outside these fields reads as zero and ignores writes, including the device-specific area from offset 0x40 up.

After reset a small two-state machine holds the function in configuration-only mode (`MODE_CFG_ONLY`). In this mode the I/O decode, memory decode and bus-master enables are all low. The transition `T_WAKE` moves it to `MODE_LIVE` when a command write leaves at least one enable set. The transition `T_SLEEP` returns it when a command write clears all three. The enables drive the address decoders and the DMA engine of the rest of the device.

Top module: `pci_cfg_header`

## Requirements
- R1: While reset is low and after it is released, all three enables read 0, `irq_line` is 0x00, `cfg_only` is 1 and `cfg_rdata` is 0.
- R2: The dword at offset 0x00 reads {device ID, vendor ID}, with the vendor ID in bytes 0-1. Writes there are ignored.
- R3: The dword at offset 0x08 reads the revision in byte 0 and the programming interface in byte 1. The class code fills bytes 2-3, with the subclass in byte 2 and the base class in byte 3. Writes there are ignored.
- R4: The dword at offset 0x2C reads the subsystem vendor ID in bytes 0-1 and the subsystem ID in bytes 2-3. Writes there are ignored.
- R5: In the dword at offset 0x04, bit 0 is the I/O enable, bit 1 is the memory enable and bit 2 is the bus-master enable. These three bits are writable and drive the outputs of the same names. All other bits of that dword read 0.
- R6: Byte 0x3C (interrupt line) is read/write and drives `irq_line`. Byte 0x3D reads the build-time pin number and ignores writes. Bytes 0x3E-0x3F read 0.
- R7: A write changes only the bytes whose enable bit is 1, where be[n] governs offset+n. A write with all enables 0 changes nothing.
- R8: Offsets 0x0C-0x2B, 0x30-0x3B and 0x40-0xFF read zero, and writes to them change nothing.
- R9: `cfg_rdata` takes the addressed dword on the clock edge where `cfg_rd` is 1 and holds its value while `cfg_rd` is 0. A read in the same cycle as a write returns the old contents.
- R10: `cfg_only` is 1 exactly when all three enables are 0. It follows each command write from the same clock edge (`T_WAKE`, `T_SLEEP`).
- R11: Address bits [1:0] are ignored. An access goes to the dword selected by bits [7:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Byte offset into the configuration space |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_rdata | output | 32 | Registered read data |
| io_decode_en | output | 1 | I/O space decode enable |
| mem_decode_en | output | 1 | Memory space decode enable |
| bus_master_en | output | 1 | Bus-master enable |
| irq_line | output | 8 | Stored interrupt line number |
| cfg_only | output | 1 | Function answers configuration accesses only |

## Verification
Every result of this block appears on the first rising edge after the strobe that causes it, with no further delay. Register writes, the decode enables, `irq_line` and the mode output all change on the edge that samples `cfg_wr`, and `cfg_rdata` changes on the edge that samples `cfg_rd`. The bench drives each strobe on a falling edge, drops it on the next falling edge and samples every output at that same moment, exactly one edge after the stimulus. A directed read-then-idle sequence confirms that read data does not move on cycles with no read.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int CFG_ADDR_W = 8;
    localparam int CFG_DATA_W = 32;
    localparam int CFG_LANES  = CFG_DATA_W / 8;
    localparam int CFG_DW_W   = CFG_ADDR_W - 2;

    // dword indices of implemented header locations
    localparam logic [CFG_DW_W-1:0] DW_IDENT  = 6'h00;
    localparam logic [CFG_DW_W-1:0] DW_CMD    = 6'h01;
    localparam logic [CFG_DW_W-1:0] DW_CLASS  = 6'h02;
    localparam logic [CFG_DW_W-1:0] DW_SUBSYS = 6'h0B;
    localparam logic [CFG_DW_W-1:0] DW_IRQ    = 6'h0F;

    localparam int CMD_BITS = 3;

    typedef struct packed {
        logic master;
        logic mem;
        logic io;
    } cmd_en_t;

    typedef enum logic {
        MODE_CFG_ONLY = 1'b0,
        MODE_LIVE     = 1'b1
    } fn_mode_e;

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
    import cfg_hdr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hit,
    input  logic                lane0_en,
    input  logic [CMD_BITS-1:0] wbits,
    output cmd_en_t             cmd_q,
    output cmd_en_t             cmd_next
);

    always_comb begin
        cmd_next = cmd_q;
        if (wr_hit && lane0_en) begin
            cmd_next = cmd_en_t'(wbits);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_next;
        end
    end

    // R7: without a lane-0 write to the command dword, the enables keep their value
    p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && lane0_en) |=> $stable(cmd_q));

    // R5: a lane-0 command write lands the low three write bits
    p_cmd_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && lane0_en) |=> (cmd_q == cmd_en_t'($past(wbits))));

endmodule

// File: rtl/cfg_rw_byte.sv
module cfg_rw_byte #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= d;
        end
    end

    // R6: the stored interrupt line only moves on an enabled write
    p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/cfg_mode_fsm.sv
module cfg_mode_fsm
    import cfg_hdr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_en_t cmd_next,
    output logic    cfg_only
);

    fn_mode_e state_q, state_d;
    logic     any_en;

    assign any_en = cmd_next.io || cmd_next.mem || cmd_next.master;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CFG_ONLY: if (any_en)  state_d = MODE_LIVE;     // T_WAKE
            MODE_LIVE:     if (!any_en) state_d = MODE_CFG_ONLY; // T_SLEEP
            default:       state_d = MODE_CFG_ONLY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_CFG_ONLY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MODE_CFG_ONLY: cfg_only = 1'b1;
            MODE_LIVE:     cfg_only = 1'b0;
            default:       cfg_only = 1'b1;
        endcase
    end

    // R10: any enable requested while dormant wakes the function on the next edge
    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_CFG_ONLY && any_en) |=> (state_q == MODE_LIVE));

    p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LIVE && !any_en) |=> (state_q == MODE_CFG_ONLY));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
    parameter logic [15:0] DEVICE_ID  = 16'h4D01,
    parameter logic [7:0]  REVISION   = 8'h03,
    parameter logic [7:0]  PROG_IF    = 8'h10,
    parameter logic [15:0] CLASS_CODE = 16'h0280,
    parameter logic [15:0] SUB_VENDOR = 16'h1B2C,
    parameter logic [15:0] SUB_ID     = 16'hA005,
    parameter logic [7:0]  INT_PIN    = 8'h01
) (
    input  logic [CFG_DW_W-1:0]   dw_idx,
    input  cmd_en_t               cmd,
    input  logic [7:0]            line,
    output logic [CFG_DATA_W-1:0] dword
);

    localparam int PAD_CMD = CFG_DATA_W - CMD_BITS;

    always_comb begin
        case (dw_idx)
            DW_IDENT:  dword = {DEVICE_ID, VENDOR_ID};
            DW_CMD:    dword = {{PAD_CMD{1'b0}}, cmd};
            DW_CLASS:  dword = {CLASS_CODE, PROG_IF, REVISION};
            DW_SUBSYS: dword = {SUB_ID, SUB_VENDOR};
            DW_IRQ:    dword = {16'h0000, INT_PIN, line};
            default:   dword = '0;
        endcase
    end

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
    parameter logic [15:0] DEVICE_ID  = 16'h4D01,
    parameter logic [7:0]  REVISION   = 8'h03,
    parameter logic [7:0]  PROG_IF    = 8'h10,
    parameter logic [15:0] CLASS_CODE = 16'h0280,
    parameter logic [15:0] SUB_VENDOR = 16'h1B2C,
    parameter logic [15:0] SUB_ID     = 16'hA005,
    parameter logic [7:0]  INT_PIN    = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_LANES-1:0]  cfg_be,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    output logic                  io_decode_en,
    output logic                  mem_decode_en,
    output logic                  bus_master_en,
    output logic [7:0]            irq_line,
    output logic                  cfg_only
);

    logic [CFG_DW_W-1:0]   dw_idx;
    logic                  wr_cmd;
    logic                  wr_line;
    cmd_en_t               cmd_q;
    cmd_en_t               cmd_next;
    logic [CFG_DATA_W-1:0] rd_dword;
    logic                  cfg_unused;

    assign dw_idx  = cfg_addr[CFG_ADDR_W-1:2];
    assign wr_cmd  = cfg_wr && (dw_idx == DW_CMD);
    assign wr_line = cfg_wr && (dw_idx == DW_IRQ) && cfg_be[0];

    // bits that no implemented field consumes
    assign cfg_unused = ^{cfg_addr[1:0], cfg_be[CFG_LANES-1:1], cfg_wdata[CFG_DATA_W-1:8]};

    cfg_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_cmd),
        .lane0_en (cfg_be[0]),
        .wbits    (cfg_wdata[CMD_BITS-1:0]),
        .cmd_q    (cmd_q),
        .cmd_next (cmd_next)
    );

    cfg_rw_byte #(
        .WIDTH     (8),
        .RESET_VAL (8'h00)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_line),
        .d     (cfg_wdata[7:0]),
        .q     (irq_line)
    );

    cfg_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_next (cmd_next),
        .cfg_only (cfg_only)
    );

    cfg_read_mux #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REVISION   (REVISION),
        .PROG_IF    (PROG_IF),
        .CLASS_CODE (CLASS_CODE),
        .SUB_VENDOR (SUB_VENDOR),
        .SUB_ID     (SUB_ID),
        .INT_PIN    (INT_PIN)
    ) u_rmux (
        .dw_idx (dw_idx),
        .cmd    (cmd_q),
        .line   (irq_line),
        .dword  (rd_dword)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_dword;
        end
    end

    assign io_decode_en  = cmd_q.io;
    assign mem_decode_en = cmd_q.mem;
    assign bus_master_en = cmd_q.master;

    // R9: read data stays put on cycles without a read strobe
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));

    // R10: configuration-only mode never coexists with an active enable
    p_cfg_only_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_only |-> !(io_decode_en || mem_decode_en || bus_master_en));

    // R2: identity dword is constant across writes
    p_ident_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr[CFG_ADDR_W-1:2] == DW_IDENT) |=> (cfg_rdata == {DEVICE_ID, VENDOR_ID}));

    // R8: the device-specific area reads zero
    p_devspec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr[CFG_ADDR_W-1:6] != '0) |=> (cfg_rdata == '0));

endmodule

// File: tb/tb_pci_cfg_header.sv
`timescale 1ns/1ps
module tb_pci_cfg_header;

    localparam logic [15:0] T_VEN   = 16'h1B2C;
    localparam logic [15:0] T_DEV   = 16'h4D01;
    localparam logic [7:0]  T_REV   = 8'h03;
    localparam logic [7:0]  T_PIF   = 8'h10;
    localparam logic [15:0] T_CLS   = 16'h0280;
    localparam logic [15:0] T_SVEN  = 16'h1B2C;
    localparam logic [15:0] T_SID   = 16'hA005;
    localparam logic [7:0]  T_PIN   = 8'h01;

    localparam logic [31:0] ID_DW   = {T_DEV, T_VEN};
    localparam logic [31:0] CLS_DW  = {T_CLS, T_PIF, T_REV};
    localparam logic [31:0] SUB_DW  = {T_SID, T_SVEN};

    // entry: {op(1=wr), addr, be, wdata, exp_rdata, exp_en{master,mem,io}, exp_line, req}
    localparam int N_VEC = 35;
    localparam logic [91:0] VEC [N_VEC] = '{
        {1'b0, 8'h00, 4'hF, 32'h0,        ID_DW,         3'b000, 8'h00, 4'd2},  // R2
        {1'b1, 8'h00, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b000, 8'h00, 4'd2},  // R2
        {1'b0, 8'h00, 4'hF, 32'h0,        ID_DW,         3'b000, 8'h00, 4'd2},  // R2
        {1'b0, 8'h08, 4'hF, 32'h0,        CLS_DW,        3'b000, 8'h00, 4'd3},  // R3
        {1'b1, 8'h08, 4'hF, 32'h0,        32'h0,         3'b000, 8'h00, 4'd3},  // R3
        {1'b0, 8'h08, 4'hF, 32'h0,        CLS_DW,        3'b000, 8'h00, 4'd3},  // R3
        {1'b0, 8'h2C, 4'hF, 32'h0,        SUB_DW,        3'b000, 8'h00, 4'd4},  // R4
        {1'b1, 8'h2C, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b000, 8'h00, 4'd4},  // R4
        {1'b0, 8'h2C, 4'hF, 32'h0,        SUB_DW,        3'b000, 8'h00, 4'd4},  // R4
        {1'b0, 8'h3C, 4'hF, 32'h0,        32'h00000100,  3'b000, 8'h00, 4'd6},  // R6
        {1'b1, 8'h3C, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b000, 8'hFF, 4'd6},  // R6
        {1'b0, 8'h3C, 4'hF, 32'h0,        32'h000001FF,  3'b000, 8'hFF, 4'd6},  // R6
        {1'b1, 8'h3C, 4'h2, 32'h0,        32'h0,         3'b000, 8'hFF, 4'd6},  // R6 pin RO
        {1'b0, 8'h3C, 4'hF, 32'h0,        32'h000001FF,  3'b000, 8'hFF, 4'd6},  // R6
        {1'b1, 8'h3C, 4'h0, 32'h0,        32'h0,         3'b000, 8'hFF, 4'd7},  // R7 no lanes
        {1'b0, 8'h3C, 4'hF, 32'h0,        32'h000001FF,  3'b000, 8'hFF, 4'd7},  // R7
        {1'b1, 8'h3C, 4'h1, 32'h0000000A, 32'h0,         3'b000, 8'h0A, 4'd7},  // R7
        {1'b0, 8'h3C, 4'hF, 32'h0,        32'h0000010A,  3'b000, 8'h0A, 4'd7},  // R7
        {1'b1, 8'h04, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b111, 8'h0A, 4'd5},  // R5
        {1'b0, 8'h04, 4'hF, 32'h0,        32'h00000007,  3'b111, 8'h0A, 4'd5},  // R5
        {1'b1, 8'h04, 4'hE, 32'h0,        32'h0,         3'b111, 8'h0A, 4'd7},  // R7 lane0 off
        {1'b0, 8'h04, 4'hF, 32'h0,        32'h00000007,  3'b111, 8'h0A, 4'd7},  // R7
        {1'b1, 8'h04, 4'h1, 32'h00000002, 32'h0,         3'b010, 8'h0A, 4'd5},  // R5
        {1'b0, 8'h04, 4'hF, 32'h0,        32'h00000002,  3'b010, 8'h0A, 4'd5},  // R5
        {1'b0, 8'h40, 4'hF, 32'h0,        32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b1, 8'h40, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b0, 8'h40, 4'hF, 32'h0,        32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b0, 8'hFC, 4'hF, 32'h0,        32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b1, 8'h0C, 4'hF, 32'hFFFFFFFF, 32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b0, 8'h0C, 4'hF, 32'h0,        32'h0,         3'b010, 8'h0A, 4'd8},  // R8
        {1'b0, 8'h3F, 4'hF, 32'h0,        32'h0000010A,  3'b010, 8'h0A, 4'd11}, // R11
        {1'b1, 8'h05, 4'h1, 32'h00000001, 32'h0,         3'b001, 8'h0A, 4'd11}, // R11
        {1'b0, 8'h06, 4'hF, 32'h0,        32'h00000001,  3'b001, 8'h0A, 4'd11}, // R11
        {1'b1, 8'h04, 4'h1, 32'h0,        32'h0,         3'b000, 8'h0A, 4'd10}, // R10
        {1'b0, 8'h04, 4'hF, 32'h0,        32'h0,         3'b000, 8'h0A, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_wr;
    logic        cfg_rd;
    logic [31:0] cfg_rdata;
    logic        io_decode_en, mem_decode_en, bus_master_en;
    logic [7:0]  irq_line;
    logic        cfg_only;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pci_cfg_header #(
        .VENDOR_ID (T_VEN), .DEVICE_ID (T_DEV), .REVISION (T_REV), .PROG_IF (T_PIF),
        .CLASS_CODE (T_CLS), .SUB_VENDOR (T_SVEN), .SUB_ID (T_SID), .INT_PIN (T_PIN)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cfg_addr (cfg_addr), .cfg_be (cfg_be),
        .cfg_wdata (cfg_wdata), .cfg_wr (cfg_wr), .cfg_rd (cfg_rd), .cfg_rdata (cfg_rdata),
        .io_decode_en (io_decode_en), .mem_decode_en (mem_decode_en),
        .bus_master_en (bus_master_en), .irq_line (irq_line), .cfg_only (cfg_only)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // strobe on a falling edge, release and sample on the next one
    task automatic access(input logic wr, input logic [7:0] a, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = wd; cfg_wr = wr; cfg_rd = !wr;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
    endtask

    task automatic check_outputs(input string req, input logic [2:0] en, input logic [7:0] line);
        check(req, "enables", {29'h0, bus_master_en, mem_decode_en, io_decode_en}, {29'h0, en});
        check(req, "irq_line", {24'h0, irq_line}, {24'h0, line});
        check("R10", "cfg_only", {31'h0, cfg_only}, {31'h0, (en == 3'b000)});
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "rdata", cfg_rdata, 32'h0);
        check_outputs("R1", 3'b000, 8'h00);

        for (int i = 0; i < N_VEC; i++) begin
            logic [91:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[3:0]);
            access(v[91], v[90:83], v[82:79], v[78:47]);
            if (!v[91]) check(tag, $sformatf("rdata vec %0d", i), cfg_rdata, v[46:15]);
            check_outputs(tag, v[14:12], v[11:4]);
        end

        // R10: bus-master alone wakes the function (T_WAKE), clearing it sleeps (T_SLEEP)
        access(1'b1, 8'h04, 4'h1, 32'h00000004);
        check_outputs("R10", 3'b100, 8'h0A);
        access(1'b1, 8'h04, 4'hF, 32'h0);
        check_outputs("R10", 3'b000, 8'h0A);

        // R9: data appears one edge after the read and holds without a read
        access(1'b0, 8'h00, 4'hF, 32'h0);
        check("R9", "rdata after read", cfg_rdata, ID_DW);
        @(negedge clk);
        cfg_addr = 8'h2C;
        @(negedge clk);
        check("R9", "rdata held", cfg_rdata, ID_DW);
        access(1'b1, 8'h3C, 4'h1, 32'h00000055);
        check("R9", "rdata held over write", cfg_rdata, ID_DW);

        // R9: read concurrent with write returns old line value
        @(negedge clk);
        cfg_addr = 8'h3C; cfg_be = 4'h1; cfg_wdata = 32'h00000077; cfg_wr = 1'b1; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        check("R9", "read during write", cfg_rdata, 32'h00000155);
        check("R6", "line after write", {24'h0, irq_line}, 32'h00000077);

        // R1: reset mid-run clears writable state
        access(1'b1, 8'h04, 4'h1, 32'h00000003);
        check_outputs("R5", 3'b011, 8'h77);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_outputs("R1", 3'b000, 8'h00);
        check("R1", "rdata in reset", cfg_rdata, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 8'h04, 4'hF, 32'h0);
        check("R1", "command after reset", cfg_rdata, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule